// File: doc/BRIEF.md
# USB Device-Mode State Controller

This block holds the device-side control state of a dual-role USB controller. It follows the controller enable bit and the role input, which is high for device and low for host, and from them tracks two device states: Reset and Idle. While the block is Idle it drives a pull-up request onto one data line. The line is picked by the speed bit. The request is raised only while the detach bit is clear and bus power is present.

The block also watches the line state for a bus reset, which is a long SE0 driven by the host. When the SE0 has lasted a programmable number of clocks, the block flags the event with a one-cycle pulse. On that same clock edge it applies a clean-up in hardware: the clock-freeze bit is set, the device is detached, every endpoint bank is released and every endpoint except endpoint 0 is disabled.

Software reaches the configuration through a narrow write port. There are three registers: control, endpoint enables and bank allocation. The current value of each register is always visible on the outputs. The block covers endpoint 0 and seven more endpoints by default.

Top module: `usbdev_state_ctl`

## Requirements
- R1: After `rst_n` is low, the outputs are: `dev_idle`=0, `ctl_enable`=0, `ctl_detach`=1, `ctl_frzclk`=1, `ctl_lowspeed`=0, `ep_enable`=0x01, `ep_alloc`=0, both pull requests 0 and `bus_reset_pulse`=0.
- R2: `dev_idle` becomes 1 on the clock edge after one where `ctl_enable`=1 and `id_pin`=1.
- R3: `dev_idle` becomes 0 on the clock edge after any edge where `ctl_enable`=0 or `id_pin`=0, whatever the previous state.
- R4: A write with `wr_valid`=1 takes effect on the same edge. `wr_sel`=0 writes the control register: bit0 enable, bit1 detach, bit2 clock freeze, bit3 low speed. `wr_sel`=1 writes the endpoint enables, one bit per endpoint. `wr_sel`=2 writes the bank allocation bits. `wr_sel`=3 changes nothing. Bit 0 of `ep_enable` always reads 1.
- R5: `pull_dp` = `dev_idle` & !`ctl_detach` & `vbus` & !`ctl_lowspeed`. `pull_dm` is the same with `ctl_lowspeed`=1. Both are combinational from the current values.
- R6: While `dev_idle`=1, `line_se0` sampled high on `se0_limit` consecutive edges raises `bus_reset_pulse` for exactly one cycle after the last of those edges. A shorter run gives no pulse. A held SE0 gives only one pulse. `se0_limit`=0 disables detection. Nothing is detected while `dev_idle`=0.
- R7: On the edge that raises `bus_reset_pulse`, the block sets `ctl_frzclk`=1 and `ctl_detach`=1, clears `ep_alloc` and sets `ep_enable`=0x01. `ctl_enable`, `ctl_lowspeed` and `dev_idle` keep their values.
- R8: A register write on the same edge as the clean-up is discarded.
- R9: The clock-freeze bit has no effect on the state transitions or on the pull requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | NUM_EP | Write data |
| id_pin | input | 1 | Role input, 1 = device |
| vbus | input | 1 | Bus power present |
| line_se0 | input | 1 | Line state is SE0 (synchronized) |
| se0_limit | input | CNT_W | SE0 length that counts as bus reset, in clocks |
| dev_idle | output | 1 | Device state: 1 Idle, 0 Reset |
| pull_dp | output | 1 | Pull-up request on D+ |
| pull_dm | output | 1 | Pull-up request on D- |
| ctl_enable | output | 1 | Controller enable bit |
| ctl_detach | output | 1 | Detach bit |
| ctl_frzclk | output | 1 | Clock-freeze bit |
| ctl_lowspeed | output | 1 | Low-speed select bit |
| ep_enable | output | NUM_EP | Endpoint enable bits |
| ep_alloc | output | NUM_EP | Endpoint bank allocation bits |
| bus_reset_pulse | output | 1 | One-cycle bus reset event |

## Verification
The assertions assume that `line_se0`, `id_pin` and `vbus` are already synchronous to `clk`. They also assume that `se0_limit` does not change in the middle of an SE0 run, since the pulse timing is measured against it. The stimulus changes every input only on the falling clock edge. It reprograms `se0_limit` only while `line_se0` is low. The SE0 sequences are run only after the enable and role inputs have settled, so each observed edge has a single cause.

// File: rtl/usbdev_state_ctl.sv
module usbdev_state_ctl #(
  parameter int NUM_EP = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [1:0]        wr_sel,
  input  logic [NUM_EP-1:0] wr_data,
  input  logic              id_pin,
  input  logic              vbus,
  input  logic              line_se0,
  input  logic [CNT_W-1:0]  se0_limit,
  output logic              dev_idle,
  output logic              pull_dp,
  output logic              pull_dm,
  output logic              ctl_enable,
  output logic              ctl_detach,
  output logic              ctl_frzclk,
  output logic              ctl_lowspeed,
  output logic [NUM_EP-1:0] ep_enable,
  output logic [NUM_EP-1:0] ep_alloc,
  output logic              bus_reset_pulse
);

  localparam logic [NUM_EP-1:0] EP0_ONLY = NUM_EP'(1);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;

  logic [CNT_W-1:0] se0_cnt;
  logic             cleanup;
  logic             attach_ok;

  assign cleanup   = dev_idle && line_se0 &&
                     (({1'b0, se0_cnt} + 1'b1) == {1'b0, se0_limit});
  assign attach_ok = dev_idle && !ctl_detach && vbus;
  assign pull_dp   = attach_ok && !ctl_lowspeed;
  assign pull_dm   = attach_ok && ctl_lowspeed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_idle <= 1'b0;
    end else begin
      dev_idle <= ctl_enable && id_pin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      se0_cnt         <= '0;
      bus_reset_pulse <= 1'b0;
    end else begin
      bus_reset_pulse <= cleanup;
      if (dev_idle && line_se0) begin
        if (se0_cnt != CNT_MAX) se0_cnt <= se0_cnt + 1'b1;
      end else begin
        se0_cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_enable   <= 1'b0;
      ctl_detach   <= 1'b1;
      ctl_frzclk   <= 1'b1;
      ctl_lowspeed <= 1'b0;
      ep_enable    <= EP0_ONLY;
      ep_alloc     <= '0;
    end else if (cleanup) begin
      ctl_frzclk <= 1'b1;
      ctl_detach <= 1'b1;
      ep_enable  <= EP0_ONLY;
      ep_alloc   <= '0;
    end else if (wr_valid) begin
      case (wr_sel)
        2'd0: begin
          ctl_enable   <= wr_data[0];
          ctl_detach   <= wr_data[1];
          ctl_frzclk   <= wr_data[2];
          ctl_lowspeed <= wr_data[3];
        end
        2'd1:    ep_enable <= wr_data | EP0_ONLY;
        2'd2:    ep_alloc  <= wr_data;
        default: ;
      endcase
    end
  end

endmodule

module usbdev_state_ctl_chk #(
  parameter int NUM_EP = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              id_pin,
  input logic              vbus,
  input logic              line_se0,
  input logic              dev_idle,
  input logic              pull_dp,
  input logic              pull_dm,
  input logic              ctl_enable,
  input logic              ctl_detach,
  input logic              ctl_lowspeed,
  input logic              ctl_frzclk,
  input logic [NUM_EP-1:0] ep_enable,
  input logic [NUM_EP-1:0] ep_alloc,
  input logic              bus_reset_pulse
);

  a_r2_enter_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_enable && id_pin) |=> dev_idle);

  a_r3_leave_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_enable || !id_pin) |=> !dev_idle);

  a_r4_ep0_on: assert property (@(posedge clk) disable iff (!rst_n)
    ep_enable[0]);

  a_r5_pull_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_dp || pull_dm) |-> (dev_idle && vbus && !ctl_detach));

  a_r5_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pull_dp, pull_dm}));

  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_pulse |-> ($past(line_se0) && $past(dev_idle)));

  a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_pulse |=> !bus_reset_pulse);

  a_r7_cleanup: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_pulse |-> (ctl_frzclk && ctl_detach && ep_alloc == '0 &&
                         ep_enable == NUM_EP'(1)));

  a_r7_keep_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_pulse |-> ($stable(ctl_enable) && $stable(ctl_lowspeed)));

endmodule

bind usbdev_state_ctl usbdev_state_ctl_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk(clk), .rst_n(rst_n), .id_pin(id_pin), .vbus(vbus),
  .line_se0(line_se0), .dev_idle(dev_idle), .pull_dp(pull_dp),
  .pull_dm(pull_dm), .ctl_enable(ctl_enable), .ctl_detach(ctl_detach),
  .ctl_lowspeed(ctl_lowspeed), .ctl_frzclk(ctl_frzclk),
  .ep_enable(ep_enable), .ep_alloc(ep_alloc),
  .bus_reset_pulse(bus_reset_pulse)
);

// File: tb/sim_usbdev_state_ctl.sv
`timescale 1ns/1ps
module sim_usbdev_state_ctl;
  localparam int NEP = 8;
  localparam int CW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [NEP-1:0] wr_data = '0;
  logic id_pin = 1'b0, vbus = 1'b0, line_se0 = 1'b0;
  logic [CW-1:0] se0_limit = '0;
  logic dev_idle, pull_dp, pull_dm, ctl_enable, ctl_detach, ctl_frzclk;
  logic ctl_lowspeed, bus_reset_pulse;
  logic [NEP-1:0] ep_enable, ep_alloc;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  usbdev_state_ctl #(.NUM_EP(NEP), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel),
    .wr_data(wr_data), .id_pin(id_pin), .vbus(vbus), .line_se0(line_se0),
    .se0_limit(se0_limit), .dev_idle(dev_idle), .pull_dp(pull_dp),
    .pull_dm(pull_dm), .ctl_enable(ctl_enable), .ctl_detach(ctl_detach),
    .ctl_frzclk(ctl_frzclk), .ctl_lowspeed(ctl_lowspeed),
    .ep_enable(ep_enable), .ep_alloc(ep_alloc),
    .bus_reset_pulse(bus_reset_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [NEP-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #4000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 idle", dev_idle, 0);
    chk("R1 ctrl", {ctl_lowspeed, ctl_frzclk, ctl_detach, ctl_enable}, 4'b0110);
    chk("R1 ep_enable", ep_enable, 8'h01);
    chk("R1 ep_alloc", ep_alloc, 0);
    chk("R1 pulls", {pull_dp, pull_dm, bus_reset_pulse}, 0);

    // R2 / R3: every enable x role combination
    for (int e = 0; e < 2; e++)
      for (int i = 0; i < 2; i++) begin
        id_pin = i[0];
        wr(2'd0, {4'b0, 4'b0010 | 4'(e)});
        chk("R2 R3 one edge", ctl_enable, e);
        @(negedge clk);
        chk((e & i) ? "R2 enter" : "R3 stay/leave", dev_idle, e & i);
      end
    // now idle; R3 via role drop alone
    id_pin = 1'b0; @(negedge clk);
    chk("R3 id drop", dev_idle, 0);
    id_pin = 1'b1; @(negedge clk);
    chk("R2 id rise", dev_idle, 1);

    // R5 / R9: full sweep of idle, detach, vbus, speed, freeze
    for (int k = 0; k < 32; k++) begin
      logic en_b, det_b, vb_b, ls_b, fz_b;
      {en_b, det_b, vb_b, ls_b, fz_b} = 5'(k);
      vbus = vb_b;
      wr(2'd0, {4'b0, ls_b, fz_b, det_b, en_b});
      @(negedge clk);
      chk("R9 state vs freeze", dev_idle, en_b);
      chk("R5 pull_dp", pull_dp, en_b & !det_b & vb_b & !ls_b);
      chk("R5 pull_dm", pull_dm, en_b & !det_b & vb_b & ls_b);
    end

    // R4 register writes
    wr(2'd1, 8'h00); chk("R4 ep0 forced", ep_enable, 8'h01);
    wr(2'd1, 8'hA6); chk("R4 ep write", ep_enable, 8'hA7);
    wr(2'd2, 8'h5A); chk("R4 alloc write", ep_alloc, 8'h5A);
    wr(2'd0, 8'h09); chk("R4 ctrl write", {ctl_lowspeed, ctl_frzclk, ctl_detach, ctl_enable}, 4'b1001);
    wr(2'd3, 8'hFF);
    chk("R4 sel3 ep", ep_enable, 8'hA7);
    chk("R4 sel3 alloc", ep_alloc, 8'h5A);
    chk("R4 sel3 ctrl", {ctl_lowspeed, ctl_frzclk, ctl_detach, ctl_enable}, 4'b1001);

    // R6 bus reset detection, limit 3
    vbus = 1'b1; se0_limit = 8'd3;
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF); @(negedge clk);
    chk("R6 precond idle", dev_idle, 1);
    line_se0 = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6 short run", bus_reset_pulse, 0);
    line_se0 = 1'b0;
    @(negedge clk);
    chk("R6 no pulse after short", bus_reset_pulse, 0);
    chk("R6 regs kept", ep_enable, 8'hFF);
    line_se0 = 1'b1;
    @(negedge clk); chk("R6 edge1", bus_reset_pulse, 0);
    @(negedge clk); chk("R6 edge2", bus_reset_pulse, 0);
    @(negedge clk); chk("R6 edge3 pulse", bus_reset_pulse, 1);
    chk("R7 frz detach", {ctl_frzclk, ctl_detach}, 2'b11);
    chk("R7 alloc", ep_alloc, 0);
    chk("R7 ep", ep_enable, 8'h01);
    chk("R7 kept", {ctl_enable, ctl_lowspeed, dev_idle}, 3'b111);
    chk("R7 pulls off", {pull_dp, pull_dm}, 0);
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      chk("R6 held no repulse", bus_reset_pulse, 0);
    end
    line_se0 = 1'b0;

    // R8 write colliding with clean-up
    wr(2'd1, 8'hFF);
    line_se0 = 1'b1;
    @(negedge clk); @(negedge clk);
    wr_valid = 1'b1; wr_sel = 2'd1; wr_data = 8'hF0;
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R8 pulse", bus_reset_pulse, 1);
    chk("R8 write lost", ep_enable, 8'h01);
    line_se0 = 1'b0; @(negedge clk);

    // R6 limit 0 disables detection
    se0_limit = 8'd0; wr(2'd1, 8'hFF);
    line_se0 = 1'b1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      chk("R6 limit0", bus_reset_pulse, 0);
    end
    chk("R6 limit0 regs", ep_enable, 8'hFF);
    line_se0 = 1'b0;

    // R6 no detection in Reset state
    se0_limit = 8'd3;
    wr(2'd0, 8'h00); @(negedge clk);
    chk("R3 disabled", dev_idle, 0);
    line_se0 = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      chk("R6 reset-state no pulse", bus_reset_pulse, 0);
    end
    chk("R6 reset-state regs", ep_enable, 8'hFF);
    line_se0 = 1'b0;

    summary();
  end
endmodule